// File: doc/BRIEF.md
# Change-Triggered Key Matrix Scanner

This block watches a 5-row by 6-column key matrix and keeps a 30-bit image of which keys are held. When it is idle it drives every row line low, so that any held key pulls its column low. It compares the column lines against the column image derived from the stored key state. A press or a release that makes the two disagree starts a scan. Scanning only begins on such a change, which keeps the matrix quiet while nothing moves.

During a scan the block drives one row low at a time, for a fixed slot of clock cycles, from row 0 up to the last row, and repeats. At the last cycle of each slot it samples the columns into the snapshot bits of that row. After the first full pass it raises an interrupt and keeps scanning until the command decoder delivers a stop strobe. If a key changed after that first pass, the next stop strobe is consumed as a short pause followed by a fresh scan, and a further stop strobe is needed to halt.

Top module: `key_scan_top`

## Requirements
- R1: After reset all row outputs are low, the interrupt is low and all 30 snapshot bits are zero.
- R2: While idle all row outputs stay low, and no scan starts while the inverted column lines equal the column image (bit c set when any stored key in column c is set).
- R3: While idle, a difference between the inverted columns and the column image (press or release) starts a scan: on the next cycle row 0 is driven low and the other rows high.
- R4: While scanning exactly one row output is low; each row holds it for SLOT_CYCLES cycles, in order row 0 to row ROWS-1, then back to row 0.
- R5: At the last cycle of a row's slot, snapshot bit r*COLS+c takes the inverted value of column c (1 = key held), with row 0 column 0 at bit 0; the snapshot does not change at any other time.
- R6: The interrupt rises at the end of the first complete pass after a scan starts and stays high until a stop strobe.
- R7: A stop strobe while scanning, with no re-arm pending, returns all rows low and clears the interrupt on the next cycle; the block is then idle.
- R8: A snapshot mismatch sampled while the interrupt is high sets a re-arm; the next stop strobe then clears the interrupt and holds all rows low for PAUSE_CYCLES cycles, after which scanning restarts at row 0; a further stop strobe during the pause or the new scan halts it.
- R9: A stop strobe while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| col_ni | input | COLS | Column return lines, low when a key on a driven row is held |
| stop_i | input | 1 | One-cycle stop strobe from the command decoder |
| row_no | output | ROWS | Row drive lines, low = row selected |
| irq_o | output | 1 | Scan interrupt |
| keys_o | output | ROWS*COLS | Key snapshot, 1 = held |

## Verification
The assertions assume the column lines are already synchronous to the clock and settle within the cycle after the row drive changes, and that stop arrives as a single-cycle strobe. The bench models the key matrix from the live row drive, so the column lines follow the rows in the same cycle, and it changes keys and stop only on falling clock edges, one stop strobe at a time.

// File: rtl/key_scan_pkg.sv
package key_scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_PAUSE = 2'd2
  } scan_state_e;
endpackage

// File: rtl/key_scan_timer.sv
module key_scan_timer #(
  parameter int ROWS        = 5,
  parameter int SLOT_CYCLES = 64,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int SW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic [RW-1:0] row_idx_o,
  output logic          slot_end_o,
  output logic          cycle_end_o
);
  logic [SW-1:0] slot_q;
  logic [RW-1:0] row_q;

  assign slot_end_o  = run_i && (slot_q == SW'(SLOT_CYCLES - 1));
  assign cycle_end_o = slot_end_o && (row_q == RW'(ROWS - 1));
  assign row_idx_o   = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      row_q  <= '0;
    end else if (!run_i) begin
      slot_q <= '0;
      row_q  <= '0;
    end else if (slot_end_o) begin
      slot_q <= '0;
      row_q  <= cycle_end_o ? '0 : row_q + RW'(1);
    end else begin
      slot_q <= slot_q + SW'(1);
    end
  end
endmodule

// File: rtl/key_scan_snapshot.sv
module key_scan_snapshot #(
  parameter int ROWS = 5,
  parameter int COLS = 6,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int NK = ROWS * COLS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sample_i,
  input  logic [RW-1:0]   row_idx_i,
  input  logic [COLS-1:0] col_ni,
  output logic [NK-1:0]   keys_o,
  output logic            mismatch_o,
  output logic            idle_change_o
);
  logic [COLS-1:0] held;
  logic [ROWS-1:0] row_diff;
  logic [COLS-1:0] col_image;

  assign held = ~col_ni;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [COLS-1:0] row_q;
    logic            hit;
    assign hit = sample_i && (row_idx_i == RW'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  row_q <= '0;
      else if (hit) row_q <= held;
    end

    assign keys_o[r*COLS +: COLS] = row_q;
    assign row_diff[r]            = hit && (row_q != held);
  end

  always_comb begin
    col_image = '0;
    for (int r = 0; r < ROWS; r++) col_image |= keys_o[r*COLS +: COLS];
  end

  assign mismatch_o    = |row_diff;
  assign idle_change_o = (col_image != held);
endmodule

// File: rtl/key_scan_ctrl.sv
module key_scan_ctrl
  import key_scan_pkg::*;
#(
  parameter int PAUSE_CYCLES = 32,
  localparam int PW = (PAUSE_CYCLES > 1) ? $clog2(PAUSE_CYCLES) : 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        stop_i,
  input  logic        idle_change_i,
  input  logic        cycle_end_i,
  input  logic        mismatch_i,
  output scan_state_e state_o,
  output logic        irq_o
);
  scan_state_e   state_q;
  logic          irq_q;
  logic          rearm_q;
  logic [PW-1:0] pause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      irq_q   <= 1'b0;
      rearm_q <= 1'b0;
      pause_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (idle_change_i) state_q <= ST_SCAN;
        end
        ST_SCAN: begin
          if (stop_i) begin
            irq_q <= 1'b0;
            if (rearm_q) begin
              // stop consumed by a late key change
              rearm_q <= 1'b0;
              pause_q <= '0;
              state_q <= ST_PAUSE;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            if (mismatch_i && irq_q) rearm_q <= 1'b1;
            if (cycle_end_i)         irq_q   <= 1'b1;
          end
        end
        ST_PAUSE: begin
          if (stop_i)                                state_q <= ST_IDLE;
          else if (pause_q == PW'(PAUSE_CYCLES - 1)) state_q <= ST_SCAN;
          else                                       pause_q <= pause_q + PW'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/key_scan_top.sv
module key_scan_top
  import key_scan_pkg::*;
#(
  parameter int ROWS         = 5,
  parameter int COLS         = 6,
  parameter int SLOT_CYCLES  = 64,
  parameter int PAUSE_CYCLES = 32,
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int NK = ROWS * COLS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [COLS-1:0] col_ni,
  input  logic            stop_i,
  output logic [ROWS-1:0] row_no,
  output logic            irq_o,
  output logic [NK-1:0]   keys_o
);
  scan_state_e   state;
  logic          run;
  logic [RW-1:0] row_idx;
  logic          slot_end;
  logic          cycle_end;
  logic          sample;
  logic          mismatch;
  logic          idle_change;

  assign run    = (state == ST_SCAN);
  assign sample = slot_end && !stop_i;

  key_scan_timer #(.ROWS(ROWS), .SLOT_CYCLES(SLOT_CYCLES)) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .row_idx_o   (row_idx),
    .slot_end_o  (slot_end),
    .cycle_end_o (cycle_end)
  );

  key_scan_snapshot #(.ROWS(ROWS), .COLS(COLS)) u_snap (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .sample_i      (sample),
    .row_idx_i     (row_idx),
    .col_ni        (col_ni),
    .keys_o        (keys_o),
    .mismatch_o    (mismatch),
    .idle_change_o (idle_change)
  );

  key_scan_ctrl #(.PAUSE_CYCLES(PAUSE_CYCLES)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .stop_i        (stop_i),
    .idle_change_i (idle_change && !run),
    .cycle_end_i   (cycle_end),
    .mismatch_i    (mismatch),
    .state_o       (state),
    .irq_o         (irq_o)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_drive
    assign row_no[r] = run ? (row_idx != RW'(r)) : 1'b0;
  end
endmodule

// File: rtl/key_scan_checker.sv
module key_scan_checker #(
  parameter int ROWS = 5,
  parameter int COLS = 6
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 stop_i,
  input logic [ROWS-1:0]      row_no,
  input logic                 irq_o,
  input logic [ROWS*COLS-1:0] keys_o
);
  assert_one_row_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(~row_no) == 1) || (row_no == '0));

  assert_irq_at_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> !row_no[0]);

  assert_irq_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !stop_i |=> irq_o);

  assert_stop_rows_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_no != '0) && stop_i |=> (row_no == '0) && !irq_o);

  assert_snap_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_no == '0) |=> $stable(keys_o));
endmodule

bind key_scan_top key_scan_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .stop_i (stop_i),
  .row_no (row_no),
  .irq_o  (irq_o),
  .keys_o (keys_o)
);

// File: tb/key_scan_top_tb.sv
module key_scan_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS  = 5;
  localparam int COLS  = 6;
  localparam int SLOT  = 64;
  localparam int PAUSE = 32;
  localparam int NK    = ROWS * COLS;
  localparam int PASS  = ROWS * SLOT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop = 1'b0;
  logic [NK-1:0] press = '0;
  logic [COLS-1:0] col_n;
  logic [ROWS-1:0] row_n;
  logic irq;
  logic [NK-1:0] keys;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  key_scan_top u_dut (
    .clk_i (clk), .rst_ni (rst_n), .col_ni (col_n), .stop_i (stop),
    .row_no (row_n), .irq_o (irq), .keys_o (keys)
  );

  // key matrix: a held key pulls its column low when its row is driven low
  always_comb begin
    for (int c = 0; c < COLS; c++) begin
      col_n[c] = 1'b1;
      for (int r = 0; r < ROWS; r++)
        if (!row_n[r] && press[r*COLS+c]) col_n[c] = 1'b0;
    end
  end

  // reference model
  int m_state, m_slot, m_row, m_pc;
  bit m_irq, m_rearm;
  logic [NK-1:0] m_keys;

  function automatic logic [COLS-1:0] image(logic [NK-1:0] k);
    logic [COLS-1:0] v = '0;
    for (int r = 0; r < ROWS; r++) v |= k[r*COLS +: COLS];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_slot = 0; m_row = 0; m_pc = 0;
      m_irq = 0; m_rearm = 0; m_keys = '0;
    end else begin
      case (m_state)
        0: if (image(m_keys) != ~col_n) begin m_state = 1; m_slot = 0; m_row = 0; end
        1: if (stop) begin
             m_irq = 0;
             if (m_rearm) begin m_rearm = 0; m_state = 2; m_pc = 0; end
             else m_state = 0;
           end else if (m_slot == SLOT-1) begin
             if ((m_keys[m_row*COLS +: COLS] != ~col_n) && m_irq) m_rearm = 1;
             m_keys[m_row*COLS +: COLS] = ~col_n;
             m_slot = 0;
             if (m_row == ROWS-1) begin m_row = 0; m_irq = 1; end
             else m_row++;
           end else m_slot++;
        default: if (stop) m_state = 0;
                 else if (m_pc == PAUSE-1) begin m_state = 1; m_slot = 0; m_row = 0; end
                 else m_pc++;
      endcase
    end
  end

  function automatic logic [ROWS-1:0] m_rows();
    logic [ROWS-1:0] v = '0;
    if (m_state == 1) begin v = '1; v[m_row] = 1'b0; end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R4 rows", 64'(row_n), 64'(m_rows()));
      chk("R6 irq", 64'(irq), 64'(m_irq));
      chk("R5 keys", 64'(keys), 64'(m_keys));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 rows", 64'(row_n), 64'(0));
    chk("R1 irq", 64'(irq), 64'(0));
    chk("R1 keys", 64'(keys), 64'(0));
    step(40);
    chk("R2 idle rows", 64'(row_n), 64'(0));
    pulse_stop();
    step(3);
    chk("R9 stop idle rows", 64'(row_n), 64'(0));
    chk("R9 stop idle irq", 64'(irq), 64'(0));

    // press row 2 col 3
    @(negedge clk) press[2*COLS+3] = 1'b1;
    @(negedge clk);
    chk("R3 start row0", 64'(row_n), 64'(5'b11110));
    step(SLOT);
    chk("R4 row1", 64'(row_n), 64'(5'b11101));
    wait_irq();
    step(5);
    chk("R6 irq high", 64'(irq), 64'(1));
    pulse_stop();
    chk("R7 rows low", 64'(row_n), 64'(0));
    chk("R7 irq low", 64'(irq), 64'(0));
    chk("R5 bit15", 64'(keys[15]), 64'(1));
    step(100);
    chk("R2 held key idle", 64'(row_n), 64'(0));

    // release, then a late press re-arms
    @(negedge clk) press[2*COLS+3] = 1'b0;
    wait_irq();
    @(negedge clk) press[4*COLS+5] = 1'b1;
    step(PASS + 10);
    pulse_stop();
    step(3);
    chk("R8 pause rows", 64'(row_n), 64'(0));
    chk("R8 pause irq", 64'(irq), 64'(0));
    step(PAUSE + 5);
    chk("R8 resumed", 64'(row_n != '0), 64'(1));
    wait_irq();
    pulse_stop();
    step(2);
    chk("R8 second stop", 64'(row_n), 64'(0));
    chk("R5 bit29", 64'(keys[29]), 64'(1));
    chk("R5 bit15 clear", 64'(keys[15]), 64'(0));

    // stop before the first pass ends
    @(negedge clk) press[1] = 1'b1;
    step(SLOT + 6);
    pulse_stop();
    chk("R7 early stop", 64'(row_n), 64'(0));
    chk("R5 bit1", 64'(keys[1]), 64'(1));
    step(50);
    chk("R2 matched idle", 64'(row_n), 64'(0));

    // stop during the pause
    @(negedge clk) press[1*COLS+2] = 1'b1;
    wait_irq();
    @(negedge clk) press[1*COLS+2] = 1'b0;
    step(PASS + 10);
    pulse_stop();
    step(4);
    chk("R8 in pause", 64'(row_n), 64'(0));
    pulse_stop();
    step(PAUSE + 10);
    chk("R8 stop in pause", 64'(row_n), 64'(0));

    // multi-key release while idle
    @(negedge clk) begin press[1] = 1'b0; press[4*COLS+5] = 1'b0; end
    wait_irq();
    pulse_stop();
    step(2);
    chk("R5 all released", 64'(keys), 64'(0));
    chk("R7 final idle", 64'(row_n), 64'(0));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule